// File: doc/BRIEF.md
# Stop/Wait Low-Power Mode Controller

This block sequences the two low-power modes of a small 8-bit processor core. A halt request from the core shuts the oscillator off. That silences the CPU clock and every peripheral clock. A doze request gates only the CPU clock, so enabled peripherals keep running. On entry to either mode the block pulses a control that clears the core's interrupt mask, so interrupts can wake the core.

Leaving doze takes one clock: any pending interrupt or the external interrupt line restarts the CPU clock at the next edge. Leaving halt takes only the external interrupt line. The oscillator is turned back on, and the CPU and peripheral clocks stay gated for a fixed settling window of `SETTLE_CYC` cycles (4064 by default). A device reset, asserted in any state, enters the same settling window with a reset-hold output raised. When the window ends, the block pulses a control that sets the interrupt mask. An interrupt wake leaves the mask alone.

States: RUN (core active), DOZE (CPU clock gated), HALT (oscillator off), SETTLE (oscillator restarting, counting). Transitions: RUN→HALT on a halt request; RUN→DOZE on a doze request with no halt request; DOZE→RUN on any interrupt; HALT→SETTLE on the external interrupt; SETTLE→RUN when the count completes; any state→SETTLE on reset. All outputs are flops, so the clock-enable lines never glitch.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low, and for `SETTLE_CYC`-1 cycles after it rises, `hold_rst`=1, `osc_en`=1, `cpu_clk_en`=0 and every `periph_clk_en` bit is 0.
- R2: The edge that ends a reset-started settling window gives `hold_rst`=0 and `cpu_clk_en`=1. It also raises `imask_set` for exactly one cycle.
- R3: In RUN, `osc_en`=1 and `cpu_clk_en`=1. Each `periph_clk_en[i]` equals `periph_en[i]` as sampled at the previous edge.
- R4: `stop_req` in RUN moves the block to HALT at the next edge, where `osc_en`=0, `cpu_clk_en`=0 and all `periph_clk_en` bits are 0. That edge also raises `imask_clr` for one cycle. When `stop_req` and `wait_req` are both high, `stop_req` wins.
- R5: `wait_req` without `stop_req` in RUN moves the block to DOZE at the next edge, where `osc_en`=1 and `cpu_clk_en`=0. There `periph_clk_en` follows `periph_en` with one cycle of delay, and `imask_clr` pulses for one cycle.
- R6: In DOZE, `irq_pend` or `ext_irq` gives `cpu_clk_en`=1 at the very next edge, with `imask_set` left at 0.
- R7: In HALT, only `ext_irq` wakes the block. `irq_pend` alone leaves `osc_en`=0 and `cpu_clk_en`=0.
- R8: `ext_irq` in HALT enters SETTLE at the next edge, where `osc_en`=1, `hold_rst`=0, `cpu_clk_en`=0 and the peripheral clocks are 0. The block stays in SETTLE for `SETTLE_CYC` cycles, then returns to RUN with `imask_set` at 0.
- R9: `stop_req` and `wait_req` are ignored outside RUN.
- R10: `imask_clr` and `imask_set` are never high together, and neither stays high for two cycles in a row.
- R11: A peripheral whose `periph_en` bit was 0 at the previous edge has its clock enable at 0 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous device reset, active low |
| stop_req | input | 1 | Core executes the halt instruction |
| wait_req | input | 1 | Core executes the doze instruction |
| ext_irq | input | 1 | External interrupt line |
| irq_pend | input | 1 | Any interrupt pending |
| periph_en | input | N_PERIPH | Per-peripheral clock enable requests |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | N_PERIPH | Peripheral clock gate enables |
| hold_rst | output | 1 | Holds the core in reset during reset settling |
| imask_clr | output | 1 | One-cycle pulse: clear interrupt mask |
| imask_set | output | 1 | One-cycle pulse: set interrupt mask |

## Verification
The halt and doze requests can arrive in the same RUN cycle. The bench provokes this from a table row that raises both lines together. It judges the result by the oscillator enable dropping and the peripheral enables all clearing, as HALT requires, with exactly one `imask_clr` pulse and not the DOZE outputs. The next row raises a doze request and a pending interrupt together while halted. Staying halted with no new clear pulse shows that neither input was taken.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DOZE   = 2'd1,
        ST_HALT   = 2'd2,
        ST_SETTLE = 2'd3
    } lpm_state_e;

    // Registered control outputs other than the per-peripheral enables
    typedef struct packed {
        logic osc;
        logic cpu;
        logic hold;
        logic mclr;
        logic mset;
    } lpm_ctl_t;

    localparam lpm_ctl_t CTL_RESET = '{osc: 1'b1, cpu: 1'b0, hold: 1'b1,
                                       mclr: 1'b0, mset: 1'b0};

endpackage

// File: rtl/lpm_settle_cnt.sv
// Settling window counter: clears while idle, counts while enabled,
// flags the last cycle of a SETTLE_CYC-long window.
module lpm_settle_cnt #(
    parameter int SETTLE_CYC = 4064
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic done
);
    localparam int CNT_W = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!count_en) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = count_en && (cnt_q == LAST);

endmodule

// File: rtl/lpm_fsm.sv
// Mode sequencer: state register plus next-state decode.
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       wait_req,
    input  logic       ext_irq,
    input  logic       irq_pend,
    input  logic       settle_done,
    output lpm_state_e state_q,
    output lpm_state_e state_d,
    output logic       cause_rst_q,
    output logic       cause_rst_d
);

    // State register; reset enters the settling window with reset cause
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_SETTLE;
            cause_rst_q <= 1'b1;
        end else begin
            state_q     <= state_d;
            cause_rst_q <= cause_rst_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d     = state_q;
        cause_rst_d = cause_rst_q;
        unique case (state_q)
            ST_RUN: begin
                if (stop_req) begin
                    state_d = ST_HALT;
                end else if (wait_req) begin
                    state_d = ST_DOZE;
                end
            end
            ST_DOZE: begin
                if (ext_irq || irq_pend) begin
                    state_d = ST_RUN;
                end
            end
            ST_HALT: begin
                if (ext_irq) begin
                    state_d     = ST_SETTLE;
                    cause_rst_d = 1'b0;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    state_d     = ST_RUN;
                    cause_rst_d = 1'b0;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

endmodule

// File: rtl/lpm_gate_out.sv
// Output register: every enable and pulse comes straight from a flop,
// loaded from the next-state decode so outputs line up with the state.
module lpm_gate_out
    import lpm_pkg::*;
#(
    parameter int N_PERIPH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lpm_state_e          state_q,
    input  lpm_state_e          state_d,
    input  logic                cause_rst_q,
    input  logic                cause_rst_d,
    input  logic [N_PERIPH-1:0] periph_en,
    output logic                osc_en,
    output logic                cpu_clk_en,
    output logic                hold_rst,
    output logic                imask_clr,
    output logic                imask_set,
    output logic [N_PERIPH-1:0] periph_clk_en
);

    lpm_ctl_t ctl_d;
    lpm_ctl_t ctl_q;
    logic     periph_allow_d;

    // Output decode from the upcoming state
    always_comb begin
        ctl_d          = '0;
        periph_allow_d = 1'b0;
        unique case (state_d)
            ST_RUN: begin
                ctl_d.osc      = 1'b1;
                ctl_d.cpu      = 1'b1;
                periph_allow_d = 1'b1;
                ctl_d.mset     = (state_q == ST_SETTLE) && cause_rst_q;
            end
            ST_DOZE: begin
                ctl_d.osc      = 1'b1;
                periph_allow_d = 1'b1;
                ctl_d.mclr     = (state_q == ST_RUN);
            end
            ST_HALT: begin
                ctl_d.mclr     = (state_q == ST_RUN);
            end
            ST_SETTLE: begin
                ctl_d.osc      = 1'b1;
                ctl_d.hold     = cause_rst_d;
            end
            default: ctl_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // One gate-enable flop per peripheral
    for (genvar gi = 0; gi < N_PERIPH; gi++) begin : g_pclk
        logic en_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q <= 1'b0;
            end else begin
                en_q <= periph_allow_d & periph_en[gi];
            end
        end
        assign periph_clk_en[gi] = en_q;
    end

    assign osc_en     = ctl_q.osc;
    assign cpu_clk_en = ctl_q.cpu;
    assign hold_rst   = ctl_q.hold;
    assign imask_clr  = ctl_q.mclr;
    assign imask_set  = ctl_q.mset;

endmodule

// File: rtl/lpm_ctrl.sv
// Stop/wait low-power controller top level.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_PERIPH   = 4,
    parameter int SETTLE_CYC = 4064
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_req,
    input  logic                wait_req,
    input  logic                ext_irq,
    input  logic                irq_pend,
    input  logic [N_PERIPH-1:0] periph_en,
    output logic                osc_en,
    output logic                cpu_clk_en,
    output logic [N_PERIPH-1:0] periph_clk_en,
    output logic                hold_rst,
    output logic                imask_clr,
    output logic                imask_set
);

    lpm_state_e state_q;
    lpm_state_e state_d;
    logic       cause_rst_q;
    logic       cause_rst_d;
    logic       settle_done;

    lpm_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .wait_req    (wait_req),
        .ext_irq     (ext_irq),
        .irq_pend    (irq_pend),
        .settle_done (settle_done),
        .state_q     (state_q),
        .state_d     (state_d),
        .cause_rst_q (cause_rst_q),
        .cause_rst_d (cause_rst_d)
    );

    lpm_settle_cnt #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (state_q == ST_SETTLE),
        .done     (settle_done)
    );

    lpm_gate_out #(
        .N_PERIPH (N_PERIPH)
    ) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_q       (state_q),
        .state_d       (state_d),
        .cause_rst_q   (cause_rst_q),
        .cause_rst_d   (cause_rst_d),
        .periph_en     (periph_en),
        .osc_en        (osc_en),
        .cpu_clk_en    (cpu_clk_en),
        .hold_rst      (hold_rst),
        .imask_clr     (imask_clr),
        .imask_set     (imask_set),
        .periph_clk_en (periph_clk_en)
    );

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
    import lpm_pkg::*;
#(
    parameter int N_PERIPH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stop_req,
    input logic                wait_req,
    input logic                ext_irq,
    input logic                irq_pend,
    input logic [N_PERIPH-1:0] periph_en,
    input logic                osc_en,
    input logic                cpu_clk_en,
    input logic [N_PERIPH-1:0] periph_clk_en,
    input logic                hold_rst,
    input logic                imask_clr,
    input logic                imask_set,
    input lpm_state_e          state_q
);

    assert_hold_settle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst |-> (osc_en && !cpu_clk_en && periph_clk_en == '0));

    assert_release_sets_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_rst) |-> (imask_set && cpu_clk_en));

    assert_run_clocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cpu_clk_en && osc_en));

    assert_halt_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_req) |=> (!osc_en && !cpu_clk_en && imask_clr));

    assert_doze_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wait_req && !stop_req) |=> (osc_en && !cpu_clk_en && imask_clr));

    assert_doze_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOZE && (ext_irq || irq_pend)) |=> (cpu_clk_en && !imask_set));

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !ext_irq) |=> (!osc_en && !cpu_clk_en));

    assert_settle_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> (osc_en && !cpu_clk_en && periph_clk_en == '0));

    assert_doze_ignores_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOZE && !ext_irq && !irq_pend) |=> (state_q == ST_DOZE && !imask_clr));

    assert_mask_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(imask_clr && imask_set));

    assert_mask_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_clr || imask_set) |=> (!imask_clr && !imask_set));

    assert_periph_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_clk_en & ~$past(periph_en)) == '0);

endmodule

bind lpm_ctrl lpm_ctrl_chk #(
    .N_PERIPH (N_PERIPH)
) u_lpm_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_req      (stop_req),
    .wait_req      (wait_req),
    .ext_irq       (ext_irq),
    .irq_pend      (irq_pend),
    .periph_en     (periph_en),
    .osc_en        (osc_en),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .hold_rst      (hold_rst),
    .imask_clr     (imask_clr),
    .imask_set     (imask_set),
    .state_q       (state_q)
);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/100ps
module test_lpm_ctrl;

    localparam int NP  = 4;
    localparam int SET = 4064;
    localparam int NV  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_req = 1'b0;
    logic          wait_req = 1'b0;
    logic          ext_irq = 1'b0;
    logic          irq_pend = 1'b0;
    logic [NP-1:0] periph_en = '0;
    logic          osc_en;
    logic          cpu_clk_en;
    logic [NP-1:0] periph_clk_en;
    logic          hold_rst;
    logic          imask_clr;
    logic          imask_set;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    lpm_ctrl #(.N_PERIPH(NP), .SETTLE_CYC(SET)) i_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
        .ext_irq(ext_irq), .irq_pend(irq_pend), .periph_en(periph_en),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .hold_rst(hold_rst), .imask_clr(imask_clr), .imask_set(imask_set)
    );

    // Row: [20:17] requirement number, [16:13] {stop,wait,ext,pend},
    // [12:9] periph_en, [8:4] expected {osc,cpu,hold,clr,set}, [3:0] periph_clk_en
    localparam logic [20:0] VEC [NV] = '{
        {4'd3,  4'b0000, 4'b1010, 5'b11000, 4'b1010}, // R3 run, enables follow
        {4'd3,  4'b0000, 4'b0101, 5'b11000, 4'b0101}, // R3 new enable pattern
        {4'd5,  4'b0100, 4'b0101, 5'b10010, 4'b0101}, // R5 doze entry
        {4'd9,  4'b1000, 4'b0111, 5'b10000, 4'b0111}, // R9 halt req in doze ignored; R11 bit3 off
        {4'd6,  4'b0001, 4'b0111, 5'b11000, 4'b0111}, // R6 pending irq wakes doze
        {4'd4,  4'b1100, 4'b1111, 5'b00010, 4'b0000}, // R4 both requests, halt wins
        {4'd7,  4'b0101, 4'b1111, 5'b00000, 4'b0000}, // R7 pend alone ignored, R9 doze req ignored
        {4'd9,  4'b0100, 4'b1111, 5'b00000, 4'b0000}  // R9 still halted
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] outs();
        return {osc_en, cpu_clk_en, hold_rst, imask_clr, imask_set, periph_clk_en};
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        // R1 reset state while held
        periph_en = 4'b1111;
        repeat (3) step();
        check("R1 during reset", outs(), 9'b10100_0000);
        rst_n = 1'b1;
        repeat (SET - 1) step();
        check("R1 last settle cycle after reset", outs(), 9'b10100_0000);
        step();
        check("R2 release after reset", outs(), 9'b11001_1111);
        periph_en = '0;
        step();
        check("R2 set pulse one cycle", outs(), 9'b11000_0000);

        // Table walk from RUN
        for (int i = 0; i < NV; i++) begin
            {stop_req, wait_req, ext_irq, irq_pend} = VEC[i][16:13];
            periph_en = VEC[i][12:9];
            step();
            check($sformatf("R%0d table row %0d", VEC[i][20:17], i), outs(), VEC[i][8:0]);
        end
        {stop_req, wait_req, ext_irq, irq_pend} = 4'b0000;

        // R8 halt -> settle via external interrupt
        ext_irq = 1'b1;
        step();
        ext_irq = 1'b0;
        check("R8 settle entry", outs(), 9'b10000_0000);
        repeat (SET - 1) step();
        check("R8 last settle cycle", outs(), 9'b10000_0000);
        step();
        check("R8 run after settle, no mask set", outs(), 9'b11000_1111);

        // R6 doze left by external interrupt
        wait_req = 1'b1;
        step();
        wait_req = 1'b0;
        check("R5 doze entry again", outs(), 9'b10010_1111);
        ext_irq = 1'b1;
        step();
        ext_irq = 1'b0;
        check("R6 ext irq wakes doze", outs(), 9'b11000_1111);

        // R1 reset arriving in doze
        wait_req = 1'b1;
        step();
        wait_req = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1 reset in doze", outs(), 9'b10100_0000);
        step();
        rst_n = 1'b1;
        repeat (SET - 1) step();
        check("R1 hold kept before release", outs(), 9'b10100_0000);
        step();
        check("R2 release after reset in doze", outs(), 9'b11001_1111);
        step();
        check("R10 set pulse gone", outs(), 9'b11000_1111);

        summary();
    end

endmodule